// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard control logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the instruction sitting in the decode stage and at the destination and write-enable of the instructions now in execute and memory. From these it decides three things. First, for each ALU operand, whether the value the consumer needs must come from a bypass path instead of the register file. Second, whether fetch and decode must freeze for a cycle while a no-op bubble enters execute. Third, whether fetch must stop while a conditional branch resolves.

Forwarding selects are worked out while the consumer is in decode and registered, so they are valid in the cycle the consumer occupies execute. A load in execute cannot forward in time, so a dependent instruction in decode waits one cycle. The block also waits one cycle when a side producer has announced a register-file write in the same writeback slot the decode instruction would use. Conditional branches never use prediction. The fall-through fetch is blocked for a fixed number of cycles (`BR_WAIT`) while the branch itself moves on. The register file is taken to be write-through, so a producer already in writeback needs no bypass.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After synchronous reset both forwarding selects read 00 and no branch wait is pending, so a no-op in decode gives pc_hold, dec_hold, dec_squash and ex_bubble all 0.
- R2: Instruction fields: opcode in bits 31:26, first source in 25:21, second source in 20:16. Opcodes 0x00 and 0x01 and stores 0x28–0x2F read both sources. Opcodes 0x02, 0x03, 0x06, 0x07, 0x0F, 0x10, 0x11 and 0x15 read none. Every other opcode reads the first source only.
- R3: If a used source equals the destination of a write-enabled, non-load instruction in execute, that operand's select becomes 01 (execute/memory latch) in the next cycle.
- R4: If a used source matches only the write-enabled instruction in memory, that operand's select becomes 10 (memory/writeback latch) in the next cycle; with no match it becomes 00.
- R5: When the execute and memory instructions both target the matched source, the execute one wins (01).
- R6: Register index 0 never matches, for either sources or destinations.
- R7: A load (execute opcode 0x20–0x27) whose destination is a used source of the decode instruction raises pc_hold, dec_hold and ex_bubble for that cycle. The selects registered in that cycle are 00.
- R8: When alt_wr_due is high and the decode instruction writes a nonzero register, the unit raises pc_hold, dec_hold and ex_bubble. The writing opcodes and their destinations are: 0x00 writes bits 15:11; 0x03 and 0x13 write register 31; every opcode outside 0x01, 0x02, 0x04–0x07, 0x10–0x12, 0x15 and 0x28–0x2F writes bits 20:16.
- R9: Opcodes 0x04–0x07 in decode, with no stall from R7 or R8, raise pc_hold and dec_squash for BR_WAIT consecutive cycles starting that cycle, with dec_hold and ex_bubble low. During the following BR_WAIT−1 cycles the decode input has no effect on any output.
- R10: A stall from R7 or R8 takes precedence over a branch in decode: the branch wait starts only in the first cycle the branch is free of such a stall, and dec_hold and dec_squash are never high together.
- R11: Register fields an opcode does not read (per R2) never cause forwarding or a load stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_instr | input | 21 | Bits 31:11 of the decode-stage instruction |
| ex_opcode | input | 6 | Opcode of the instruction in execute |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_rd | input | 5 | Destination of the execute instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| alt_wr_due | input | 1 | A side producer claims the write port in the writeback slot of the decode instruction |
| fwd_a_sel | output | 2 | First-operand bypass select for execute: 00 regfile, 01 execute/memory latch, 10 memory/writeback latch |
| fwd_b_sel | output | 2 | Second-operand bypass select, same encoding |
| pc_hold | output | 1 | Freeze the PC |
| dec_hold | output | 1 | Freeze the fetch/decode latch |
| dec_squash | output | 1 | Load a no-op into the fetch/decode latch |
| ex_bubble | output | 1 | Load a no-op into the decode/execute latch |

## Verification
The assertions assume the pipeline obeys the unit. The execute and memory inputs must describe the instructions that really followed the stall and bubble decisions. During a branch wait the decode latch must hold a no-op, and alt_wr_due must always refer to the writeback slot of the current decode instruction. The stimulus draws register fields from r0–r3 only, so matches, r0 cases and double matches happen often. The directed part keeps the execute and memory inputs consistent with the bubbles it has caused. The random part mixes loads, branches, jumps and stores so that every stall and bypass case competes with the others.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int OP_W   = 6;
    localparam int REG_W  = 5;
    localparam int N_SRC  = 2;
    localparam int LINK_REG = 31;

    typedef logic [OP_W-1:0]  opcode_t;
    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_EXMEM = 2'b01,
        FWD_MEMWB = 2'b10
    } fwd_sel_e;

    localparam opcode_t OPC_RREG = 6'h00;
    localparam opcode_t OPC_FREG = 6'h01;
    localparam opcode_t OPC_JMP  = 6'h02;
    localparam opcode_t OPC_JLNK = 6'h03;
    localparam opcode_t OPC_BRZ  = 6'h04;
    localparam opcode_t OPC_BRNZ = 6'h05;
    localparam opcode_t OPC_BFT  = 6'h06;
    localparam opcode_t OPC_BFF  = 6'h07;
    localparam opcode_t OPC_HIMM = 6'h0f;
    localparam opcode_t OPC_RET  = 6'h10;
    localparam opcode_t OPC_TRP  = 6'h11;
    localparam opcode_t OPC_JREG = 6'h12;
    localparam opcode_t OPC_JRLK = 6'h13;
    localparam opcode_t OPC_IDLE = 6'h15;

    typedef struct packed {
        logic     use_a;
        logic     use_b;
        logic     writes;
        logic     is_cbr;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
    } dec_info_t;

    function automatic logic is_load_op(opcode_t op);
        return op[5:3] == 3'b100;
    endfunction

    function automatic logic is_store_op(opcode_t op);
        return op[5:3] == 3'b101;
    endfunction

endpackage

// File: rtl/hz_decode.sv
module hz_decode
    import hz_pkg::*;
(
    input  logic [31:11] instr,
    input  logic         valid,
    output dec_info_t    info
);

    opcode_t op;

    always_comb begin
        op          = instr[31:26];
        info        = '0;
        info.src_a  = instr[25:21];
        info.src_b  = instr[20:16];
        info.dst    = instr[20:16];
        case (op)
            OPC_RREG: begin
                info.use_a  = 1'b1;
                info.use_b  = 1'b1;
                info.writes = 1'b1;
                info.dst    = instr[15:11];
            end
            OPC_FREG: begin
                info.use_a = 1'b1;
                info.use_b = 1'b1;
            end
            OPC_JMP, OPC_RET, OPC_TRP, OPC_IDLE: ;
            OPC_JLNK: begin
                info.writes = 1'b1;
                info.dst    = reg_idx_t'(LINK_REG);
            end
            OPC_BRZ, OPC_BRNZ: begin
                info.use_a  = 1'b1;
                info.is_cbr = 1'b1;
            end
            OPC_BFT, OPC_BFF: info.is_cbr = 1'b1;
            OPC_JREG: info.use_a = 1'b1;
            OPC_JRLK: begin
                info.use_a  = 1'b1;
                info.writes = 1'b1;
                info.dst    = reg_idx_t'(LINK_REG);
            end
            OPC_HIMM: info.writes = 1'b1;
            default: begin
                info.use_a = 1'b1;
                if (is_store_op(op)) begin
                    info.use_b = 1'b1;
                end else begin
                    info.writes = 1'b1;
                end
            end
        endcase
        if (!valid) begin
            info = '0;
        end
    end

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
(
    input  logic     use_src,
    input  reg_idx_t src,
    input  logic     ex_wr,
    input  reg_idx_t ex_rd,
    input  logic     ex_load,
    input  logic     mem_wr,
    input  reg_idx_t mem_rd,
    output fwd_sel_e sel_nxt,
    output logic     load_dep
);

    logic live;
    logic ex_hit;
    logic mem_hit;

    assign live     = use_src && (src != '0);
    assign ex_hit   = live && ex_wr && (ex_rd == src);
    assign mem_hit  = live && mem_wr && (mem_rd == src);
    assign load_dep = ex_hit && ex_load;

    always_comb begin
        if (ex_hit) begin
            sel_nxt = FWD_EXMEM;
        end else if (mem_hit) begin
            sel_nxt = FWD_MEMWB;
        end else begin
            sel_nxt = FWD_RF;
        end
    end

endmodule

// File: rtl/hz_branch_seq.sv
module hz_branch_seq #(
    parameter int BR_WAIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic shadow
);

    localparam int CW = $clog2(BR_WAIT + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BR_WAIT - 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= RELOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign shadow = (left_q != '0);

    AST_NO_RESTART_IN_SHADOW: assert property (@(posedge clk) disable iff (rst)
        shadow |-> !start) else $error("branch restarted inside wait"); // R9

    AST_SHADOW_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |=> (shadow == (BR_WAIT > 1))) else $error("wait length wrong"); // R9

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int BR_WAIT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:11] id_instr,
    input  logic [5:0]  ex_opcode,
    input  logic        ex_wr_en,
    input  logic [4:0]  ex_rd,
    input  logic        mem_wr_en,
    input  logic [4:0]  mem_rd,
    input  logic        alt_wr_due,
    output logic [1:0]  fwd_a_sel,
    output logic [1:0]  fwd_b_sel,
    output logic        pc_hold,
    output logic        dec_hold,
    output logic        dec_squash,
    output logic        ex_bubble
);

    dec_info_t        dinfo;
    logic             shadow;
    logic             dec_valid;
    logic             ex_load;
    logic             port_clash;
    logic             data_stall;
    logic             br_start;
    logic [N_SRC-1:0] ld_dep;
    logic             src_use [N_SRC];
    reg_idx_t         src_idx [N_SRC];
    fwd_sel_e         sel_nxt [N_SRC];
    fwd_sel_e         sel_q   [N_SRC];

    assign dec_valid = !shadow;
    assign ex_load   = is_load_op(ex_opcode);

    hz_decode u_decode (
        .instr (id_instr),
        .valid (dec_valid),
        .info  (dinfo)
    );

    assign src_use[0] = dinfo.use_a;
    assign src_use[1] = dinfo.use_b;
    assign src_idx[0] = dinfo.src_a;
    assign src_idx[1] = dinfo.src_b;

    for (genvar k = 0; k < N_SRC; k++) begin : g_operand
        hz_fwd_pick u_pick (
            .use_src  (src_use[k]),
            .src      (src_idx[k]),
            .ex_wr    (ex_wr_en),
            .ex_rd    (ex_rd),
            .ex_load  (ex_load),
            .mem_wr   (mem_wr_en),
            .mem_rd   (mem_rd),
            .sel_nxt  (sel_nxt[k]),
            .load_dep (ld_dep[k])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[k] <= FWD_RF;
            end else if (data_stall || !dec_valid) begin
                sel_q[k] <= FWD_RF;
            end else begin
                sel_q[k] <= sel_nxt[k];
            end
        end
    end

    assign port_clash = alt_wr_due && dinfo.writes && (dinfo.dst != '0);
    assign data_stall = (|ld_dep) || port_clash;
    assign br_start   = dinfo.is_cbr && !data_stall;

    hz_branch_seq #(.BR_WAIT(BR_WAIT)) u_branch (
        .clk    (clk),
        .rst    (rst),
        .start  (br_start),
        .shadow (shadow)
    );

    assign pc_hold    = data_stall || br_start || shadow;
    assign dec_hold   = data_stall;
    assign dec_squash = br_start || shadow;
    assign ex_bubble  = data_stall;
    assign fwd_a_sel  = sel_q[0];
    assign fwd_b_sel  = sel_q[1];

    AST_LOAD_USE_STALLS: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && ex_wr_en && ex_load && ex_rd != '0 && dinfo.use_a && dinfo.src_a == ex_rd)
        |-> ex_bubble) else $error("load-use not stalled"); // R7

    AST_BUBBLE_CLEARS_FWD: assert property (@(posedge clk) disable iff (rst)
        ex_bubble |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00)) else $error("bypass after bubble"); // R7

    AST_PORT_CLASH_STALLS: assert property (@(posedge clk) disable iff (rst)
        (alt_wr_due && dinfo.writes && dinfo.dst != '0) |-> (ex_bubble && !dec_squash))
        else $error("write-port clash missed"); // R8

    AST_HOLD_SQUASH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dec_hold && dec_squash)) else $error("hold and squash together"); // R10

    AST_EX_WINS: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !ex_bubble && dinfo.use_a && dinfo.src_a != '0 && ex_wr_en &&
         ex_rd == dinfo.src_a && mem_wr_en && mem_rd == dinfo.src_a)
        |=> fwd_a_sel == 2'b01) else $error("priority wrong"); // R5

    AST_R0_NEVER_FWD: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && id_instr[25:21] == 5'd0) |=> fwd_a_sel == 2'b00) else $error("r0 bypassed"); // R6

endmodule

// File: tb/pipe_hazard_unit_bench.sv
`timescale 1ns/1ps
module pipe_hazard_unit_bench;

    localparam int BRW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h5400_0000;
    logic [5:0]  ex_op = 6'h15;
    logic        ex_wr = 1'b0;
    logic [4:0]  ex_rd = '0;
    logic        mem_wr = 1'b0;
    logic [4:0]  mem_rd = '0;
    logic        alt_due = 1'b0;
    logic [1:0]  fa, fb;
    logic        ph, dh, ds, eb;

    int nchk = 0;
    int nfail = 0;
    int br_left = 0;
    int exp_a = 0;
    int exp_b = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pipe_hazard_unit #(.BR_WAIT(BRW)) u_pipe_hazard_unit (
        .clk(clk), .rst(rst), .id_instr(instr[31:11]), .ex_opcode(ex_op),
        .ex_wr_en(ex_wr), .ex_rd(ex_rd), .mem_wr_en(mem_wr), .mem_rd(mem_rd),
        .alt_wr_due(alt_due), .fwd_a_sel(fa), .fwd_b_sel(fb), .pc_hold(ph),
        .dec_hold(dh), .dec_squash(ds), .ex_bubble(eb)
    );

    function automatic bit reads_a(logic [5:0] op);
        if (op inside {6'h02, 6'h03, 6'h06, 6'h07, 6'h0f, 6'h10, 6'h11, 6'h15}) return 0;
        return 1;
    endfunction
    function automatic bit reads_b(logic [5:0] op);
        return (op == 6'h00) || (op == 6'h01) || (op >= 6'h28 && op <= 6'h2f);
    endfunction
    function automatic bit does_write(logic [5:0] op);
        if (op inside {6'h01, 6'h02, 6'h04, 6'h05, 6'h06, 6'h07, 6'h10, 6'h11, 6'h12, 6'h15}) return 0;
        if (op >= 6'h28 && op <= 6'h2f) return 0;
        return 1;
    endfunction
    function automatic int dest_of(logic [31:0] ins);
        if (ins[31:26] == 6'h00) return int'(ins[15:11]);
        if (ins[31:26] == 6'h03 || ins[31:26] == 6'h13) return 31;
        return int'(ins[20:16]);
    endfunction
    function automatic logic [31:0] mk(logic [5:0] op, int a, int b, int d);
        return {op, 5'(a), 5'(b), 5'(d), 11'd0};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Called just after a falling edge with inputs already driven.
    task automatic step(input string tag);
        bit valid, ld, clash, stall, br;
        bit ha_ex, hb_ex, ha_mem, hb_mem;
        int sa, sb;
        logic [5:0] op;
        #1;
        if (rst) begin
            br_left = 0; exp_a = 0; exp_b = 0;
        end else begin
            op = instr[31:26];
            valid = (br_left == 0);
            sa = int'(instr[25:21]);
            sb = int'(instr[20:16]);
            ha_ex  = valid && reads_a(op) && sa != 0 && ex_wr && int'(ex_rd) == sa;
            hb_ex  = valid && reads_b(op) && sb != 0 && ex_wr && int'(ex_rd) == sb;
            ha_mem = valid && reads_a(op) && sa != 0 && mem_wr && int'(mem_rd) == sa;
            hb_mem = valid && reads_b(op) && sb != 0 && mem_wr && int'(mem_rd) == sb;
            ld = (ex_op >= 6'h20 && ex_op <= 6'h27) && (ha_ex || hb_ex);
            clash = valid && alt_due && does_write(op) && dest_of(instr) != 0;
            stall = ld || clash;
            br = valid && !stall && (op >= 6'h04 && op <= 6'h07);
            chk(tag, "fwd_a", int'(fa), exp_a);
            chk(tag, "fwd_b", int'(fb), exp_b);
            chk(tag, "pc_hold", int'(ph), int'(stall || br || br_left > 0));
            chk(tag, "dec_hold", int'(dh), int'(stall));
            chk(tag, "dec_squash", int'(ds), int'(br || br_left > 0));
            chk(tag, "ex_bubble", int'(eb), int'(stall));
            if (!valid || stall) begin
                exp_a = 0; exp_b = 0;
            end else begin
                exp_a = ha_ex ? 1 : (ha_mem ? 2 : 0);
                exp_b = hb_ex ? 1 : (hb_mem ? 2 : 0);
            end
            if (br) br_left = BRW - 1;
            else if (br_left > 0) br_left--;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        instr = mk(6'h15, 0, 0, 0); ex_op = 6'h15; ex_wr = 0; ex_rd = 0;
        mem_wr = 0; mem_rd = 0; alt_due = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        quiet();
        step("R1"); step("R1");
        rst = 0;
        step("R1"); step("R1");

        // R3: execute producer feeds first operand
        ex_op = 6'h00; ex_wr = 1; ex_rd = 3; instr = mk(6'h00, 3, 2, 5);
        step("R3");
        quiet(); step("R3");
        // R4: memory producer feeds second operand
        mem_wr = 1; mem_rd = 2; instr = mk(6'h00, 1, 2, 5);
        step("R4");
        quiet(); step("R4");
        // R5: both stages target the source
        ex_op = 6'h08; ex_wr = 1; ex_rd = 1; mem_wr = 1; mem_rd = 1; instr = mk(6'h2b, 1, 1, 0);
        step("R5");
        quiet(); step("R5");
        // R6: register 0 never matches
        ex_op = 6'h00; ex_wr = 1; ex_rd = 0; mem_wr = 1; mem_rd = 0; instr = mk(6'h00, 0, 0, 4);
        step("R6");
        quiet(); step("R6");
        // R2 / R11: jump fields unread, store second field read
        ex_op = 6'h00; ex_wr = 1; ex_rd = 3; instr = mk(6'h03, 3, 3, 0);
        step("R11");
        quiet(); step("R11");
        ex_op = 6'h00; ex_wr = 1; ex_rd = 2; instr = mk(6'h08, 1, 2, 0);
        step("R11");
        quiet(); step("R11");
        ex_op = 6'h00; ex_wr = 1; ex_rd = 2; instr = mk(6'h29, 1, 2, 0);
        step("R2");
        quiet(); step("R2");
        // R7: load-use stall, then bypass from memory/writeback
        ex_op = 6'h23; ex_wr = 1; ex_rd = 3; instr = mk(6'h08, 3, 1, 0);
        step("R7");
        ex_op = 6'h15; ex_wr = 0; mem_wr = 1; mem_rd = 3;
        step("R7");
        quiet(); step("R7");
        // R8: write-port clash, then none with destination 0
        alt_due = 1; instr = mk(6'h08, 1, 2, 0);
        step("R8");
        alt_due = 0; step("R8");
        alt_due = 1; instr = mk(6'h08, 1, 0, 0);
        step("R8");
        instr = mk(6'h2b, 1, 2, 0);
        step("R8");
        quiet(); step("R8");
        // R9: branch wait, decode ignored during it
        instr = mk(6'h04, 1, 0, 0);
        step("R9");
        ex_op = 6'h23; ex_wr = 1; ex_rd = 2; alt_due = 1; instr = mk(6'h00, 2, 2, 3);
        step("R9");
        quiet(); step("R9"); step("R9");
        // R10: load-use before branch wait
        ex_op = 6'h20; ex_wr = 1; ex_rd = 1; instr = mk(6'h05, 1, 0, 0);
        step("R10");
        ex_op = 6'h15; ex_wr = 0; mem_wr = 1; mem_rd = 1;
        step("R10");
        quiet(); step("R10"); step("R10");

        // Mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] pool [19];
            pool = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08,
                     6'h0f, 6'h10, 6'h12, 6'h13, 6'h15, 6'h20, 6'h23, 6'h2b, 6'h29, 6'h3a};
            instr  = mk(pool[$urandom_range(0, 18)], $urandom_range(0, 3),
                        $urandom_range(0, 3), $urandom_range(0, 3));
            ex_op  = pool[$urandom_range(0, 18)];
            ex_wr  = 1'($urandom_range(0, 1));
            ex_rd  = 5'($urandom_range(0, 3));
            mem_wr = 1'($urandom_range(0, 1));
            mem_rd = 5'($urandom_range(0, 3));
            alt_due = ($urandom_range(0, 7) == 0);
            step("R3 R4 R5 R7 R8 R9 R10 mixed");
        end

        // R1: reset inside a branch wait clears it
        quiet(); instr = mk(6'h06, 0, 0, 0);
        step("R9");
        rst = 1; quiet(); step("R1");
        rst = 0; step("R1"); step("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule